// File: doc/BRIEF.md
# Period-Match Timer with Pre- and Postscaling

This block is an up-counter that advances on an instruction-rate tick. The tick first goes through a selectable prescaler (1:1, 1:4 or 1:16). The counter is compared with a period register. When an increment finds the counter equal to the period, the counter returns to zero and the block emits a one-cycle match strobe. That strobe can serve other logic as a PWM time base or as a baud clock.

Match events also go through a postscaler with a programmable ratio from 1:1 to 1:16. Each time the postscaler wraps, it sets a sticky interrupt flag, which stays set until software clears it. Software reaches the counter, the period and the control byte through a small register bus. Writes take effect at the clock edge. Reads return the data one cycle after the address is presented.

Top module: `period_timer`

## Requirements
- R1: After synchronous reset the counter is 0x00, the period register is 0xFF, the control byte is 0x00, and both the interrupt flag and the match strobe are low.
- R2: Control bits [2:1] select the prescale ratio: 00 gives one increment per tick, 01 gives one per 4 ticks, and 10 or 11 give one per 16 ticks.
- R3: An increment that finds the counter equal to the period loads zero instead of counting up, and raises `match_o` for exactly one cycle. With ticks present on every cycle, successive strobes are therefore (period+1) × prescale ratio cycles apart.
- R4: Control bits [6:3] hold a value N. The interrupt flag is set on every (N+1)-th match event, so every ratio from 1:1 to 1:16 is available.
- R5: While control bit 0 (enable) is 0, the counter holds its value and the prescaler does not advance.
- R6: Address 0 is the counter, address 1 the period and address 2 the control byte; address 3 and control bit 7 read as 0. `rd_data` shows the register at `rd_addr` one cycle later.
- R7: A write to the counter or to the control byte clears the prescaler and postscaler counts, and no increment happens in the cycle of that write.
- R8: The interrupt flag stays set until `flag_clr` is asserted. If a postscaler event arrives in the same cycle as the clear, the flag stays set.
- R9: The counter advances only in cycles where `tick_i` is high. With a 1:1 prescale it advances exactly once per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Instruction-rate count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data |
| flag_clr | input | 1 | Clears the interrupt flag |
| irq_o | output | 1 | Sticky interrupt flag |
| match_o | output | 1 | One-cycle period-match strobe |

## Verification
The hardest case to reach from the ports is a clear that lands while the prescaler or postscaler is part-way through a count. In that case the only visible trace is the length of the next interval. The bench therefore lets the 1:16 prescaler run ten ticks past a match before rewriting the counter. It then measures 16 edges to the next strobe, where a missing clear would give six. In the same way, it lets two of four postscaled matches pass before rewriting the control byte, and expects four more matches before the flag rises. A separate exhaustive sweep of all sixteen postscale values and a grid of period and prescale combinations compare each measured interval with the arithmetic product.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic [1:0] {
    A_COUNT  = 2'd0,
    A_PERIOD = 2'd1,
    A_CTRL   = 2'd2,
    A_NONE   = 2'd3
  } reg_addr_e;

  // control byte layout, bit 7 unused
  typedef struct packed {
    logic [3:0] post;
    logic [1:0] pre;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int PRE_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  input  logic       clr_i,
  output logic       inc_o
);
  localparam int MID = (1 << (PRE_W / 2)) - 1;

  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] lim;

  always_comb begin
    case (sel_i)
      2'd0:    lim = '0;
      2'd1:    lim = PRE_W'(MID);
      default: lim = '1;
    endcase
  end

  assign inc_o = tick_i & run_i & ~clr_i & (pcnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      pcnt_q <= '0;
    else if (tick_i && run_i)
      pcnt_q <= (pcnt_q == lim) ? '0 : pcnt_q + 1'b1;
  end

  // R2
  pre_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    pcnt_q <= lim);

  // R5
  pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !clr_i) |=> $stable(pcnt_q));
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign evt_o = inc_i & ~load_i & (cnt_q == period_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= load_val_i;
    else if (inc_i)
      cnt_q <= (cnt_q == period_i) ? '0 : cnt_q + 1'b1;
  end

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> (cnt_q == '0));

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ptmr_postscale.sv
module ptmr_postscale #(
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_i,
  input  logic              clr_i,
  input  logic [POST_W-1:0] lim_i,
  output logic              set_o
);
  logic [POST_W-1:0] pcnt_q;

  assign set_o = evt_i & ~clr_i & (pcnt_q == lim_i);

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      pcnt_q <= '0;
    else if (evt_i)
      pcnt_q <= (pcnt_q == lim_i) ? '0 : pcnt_q + 1'b1;
  end

  // R4
  post_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    pcnt_q <= lim_i);

  // R7
  post_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (pcnt_q == '0));
endmodule

// File: rtl/period_timer.sv
module period_timer #(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 4,
  parameter int POST_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             flag_clr,
  output logic             irq_o,
  output logic             match_o
);
  import ptmr_pkg::*;

  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt;
  logic             inc, evt, set_w, clr_w, load_w;

  assign load_w = wr_en && (reg_addr_e'(wr_addr) == A_COUNT);
  assign clr_w  = load_w || (wr_en && (reg_addr_e'(wr_addr) == A_CTRL));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '1;
    end else if (wr_en) begin
      if (reg_addr_e'(wr_addr) == A_PERIOD) period_q <= wr_data;
      if (reg_addr_e'(wr_addr) == A_CTRL)   ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  ptmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(ctrl_q.run),
    .sel_i(ctrl_q.pre), .clr_i(clr_w), .inc_o(inc)
  );

  ptmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .inc_i(inc), .load_i(load_w),
    .load_val_i(wr_data), .period_i(period_q), .cnt_o(cnt), .evt_o(evt)
  );

  ptmr_postscale #(.POST_W(POST_W)) u_post (
    .clk(clk), .rst(rst), .evt_i(evt), .clr_i(clr_w),
    .lim_i(ctrl_q.post), .set_o(set_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o   <= 1'b0;
      match_o <= 1'b0;
      rd_data <= '0;
    end else begin
      irq_o   <= set_w | (irq_o & ~flag_clr);
      match_o <= evt;
      case (reg_addr_e'(rd_addr))
        A_COUNT:  rd_data <= cnt;
        A_PERIOD: rd_data <= period_q;
        A_CTRL:   rd_data <= CNT_W'(ctrl_q);
        default:  rd_data <= '0;
      endcase
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && !match_o && period_q == '1 && cnt == '0));

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_w |=> irq_o);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !flag_clr) |=> irq_o);

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    match_o |=> !match_o || (ctrl_q.pre == 2'd0));
endmodule

// File: tb/test_period_timer.sv
module test_period_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       flag_clr = 1'b0;
  logic       irq_o, match_o;

  int errors = 0;
  int checks = 0;
  int tick_pat = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  period_timer i_period_timer (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .flag_clr(flag_clr), .irq_o(irq_o), .match_o(match_o)
  );

  function automatic logic [7:0] ctl(input bit run, input int pre, input int post);
    return {1'b0, 4'(post), 2'(pre), run};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_tick(input int p);
    tick_pat = p;
    tick_i = (p != 0);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (tick_pat == 2) tick_i = ~tick_i;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    rd_addr = a;
    step();
    d = int'(rd_data);
  endtask

  task automatic wait_match(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!match_o && n < 5000);
  endtask

  initial begin
    int v, n, m;
    int pers[4] = '{0, 1, 2, 5};
    int ratio[3] = '{1, 4, 16};
    repeat (3) step();
    rst = 1'b0;
    step();

    // R1 reset state
    check("R1 irq", int'(irq_o), 0);
    check("R1 match", int'(match_o), 0);
    rd(2'd0, v); check("R1 counter", v, 0);
    rd(2'd1, v); check("R1 period", v, 255);
    rd(2'd2, v); check("R1 control", v, 0);

    // R6 register access
    wr(2'd0, 8'h5A); rd(2'd0, v); check("R6 counter rw", v, 8'h5A);
    wr(2'd1, 8'h21); rd(2'd1, v); check("R6 period rw", v, 8'h21);
    wr(2'd2, 8'hFE); rd(2'd2, v); check("R6 control bit7 zero", v, 8'h7E);
    rd(2'd3, v); check("R6 unused addr", v, 0);

    // R5 disabled counter holds while ticking
    wr(2'd2, ctl(0, 0, 0)); wr(2'd0, 8'h40);
    set_tick(1); repeat (20) step(); set_tick(0);
    rd(2'd0, v); check("R5 hold when disabled", v, 8'h40);

    // R9 one increment per tick at 1:1
    wr(2'd1, 8'hFF); wr(2'd2, ctl(1, 0, 0)); wr(2'd0, 8'h10);
    set_tick(1); repeat (5) step(); set_tick(0);
    wr(2'd2, ctl(0, 0, 0));
    rd(2'd0, v); check("R9 five ticks", v, 8'h15);

    // R2 / R3 interval grid
    for (int s = 0; s < 3; s++) begin
      for (int p = 0; p < 4; p++) begin
        set_tick(0);
        wr(2'd1, 8'(pers[p]));
        wr(2'd0, 8'h00);
        wr(2'd2, ctl(1, s, 0));
        set_tick(1);
        wait_match(n); wait_match(n);
        check($sformatf("R2 R3 interval pre=%0d per=%0d", s, pers[p]), n, (pers[p] + 1) * ratio[s]);
      end
    end
    // R2 encoding 11 also 1:16
    set_tick(0); wr(2'd1, 8'd1); wr(2'd2, ctl(1, 3, 0)); set_tick(1);
    wait_match(n); wait_match(n);
    check("R2 sel 11 ratio", n, 32);

    // R9 ticks on alternate cycles double the interval
    set_tick(0); wr(2'd1, 8'd3); wr(2'd0, 8'd0); wr(2'd2, ctl(1, 0, 0));
    set_tick(2);
    wait_match(n); wait_match(n);
    check("R9 sparse tick interval", n, 8);

    // R4 postscale sweep
    for (int q = 0; q < 16; q++) begin
      set_tick(0);
      wr(2'd1, 8'd0);
      flag_clr = 1'b1;
      wr(2'd2, ctl(1, 0, q));
      flag_clr = 1'b0;
      set_tick(1);
      m = 0; n = 0;
      while (!irq_o && n < 200) begin
        step(); n++;
        if (match_o) m++;
      end
      check($sformatf("R4 postscale N=%0d", q), m, q + 1);
    end

    // R7 prescaler cleared by counter write
    set_tick(0); wr(2'd1, 8'd0); wr(2'd2, ctl(1, 2, 0)); set_tick(1);
    wait_match(n);
    repeat (10) step();
    wr(2'd0, 8'd0);
    wait_match(n);
    check("R7 prescaler clear", n, 16);

    // R7 postscaler cleared by control write
    set_tick(0); flag_clr = 1'b1; wr(2'd2, ctl(1, 0, 3)); flag_clr = 1'b0; set_tick(1);
    m = 0;
    while (m < 2) begin step(); if (match_o) m++; end
    flag_clr = 1'b1; wr(2'd2, ctl(1, 0, 3)); flag_clr = 1'b0;
    m = 0; n = 0;
    while (!irq_o && n < 200) begin step(); n++; if (match_o) m++; end
    check("R7 postscaler clear", m, 4);

    // R8 flag priority, clear and stickiness
    set_tick(0); wr(2'd2, ctl(1, 0, 0)); set_tick(1);
    flag_clr = 1'b1;
    repeat (4) step();
    check("R8 set beats clear", int'(irq_o), 1);
    set_tick(0); step(); step();
    check("R8 clear", int'(irq_o), 0);
    flag_clr = 1'b0;
    set_tick(1); step(); set_tick(0); step();
    repeat (10) step();
    check("R8 sticky", int'(irq_o), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule